// File: doc/BRIEF.md
# Oscillator Band Search Sequencer

This block selects which of several on-chip oscillators, and which of sixteen sub-bands within it, a frequency synthesizer should use. The goal is a PLL tuning voltage that sits inside its usable window. A single-cycle trigger starts a search. After every band change the block waits for a programmable number of settle ticks, then reads a small window ADC that measures the tuning voltage. Depending on the code it reads, it stops, moves one sub-band lower, or moves one sub-band higher. When it steps past either end of a sub-band range, it carries into the neighbouring oscillator.

The search starts either from a seed oscillator and sub-band, or from the selection currently in use. When the auto mode is off, the selection simply follows the seed inputs. At all times the block reports the chosen oscillator and sub-band, a success flag, and an idle flag.

Top module: `vco_band_search`

## Requirements
- R1: After a synchronous reset the selection is oscillator 0, sub-band 0. The success flag is 0 and the idle flag is 1.
- R2: While `auto_en` is 0, one cycle later the outputs equal `seed_osc`/`seed_sub` (including the code 3, which means shutdown). Success is 0, idle is 1, and `trig` has no effect.
- R3: A `trig` pulse with `auto_en` set and `start_cur` = 0 starts a search from the seed. On the next cycle idle is 0, success is 0, and the selection equals the seed.
- R4: With `start_cur` = 1 a search starts from the selection that is currently output, and the seed is ignored.
- R5: After the start and after each band change, the ADC is judged on the settle tick that completes 2^(WAIT_BASE_LOG2 + wait code) ticks. The wait code is captured at the trigger.
- R6: An ADC code from 1 to 6 at a judgement ends the search with success = 1, idle = 1, and the band held. While idle in auto mode the outputs stay unchanged until the next trigger.
- R7: ADC code 0 steps one sub-band down. Stepping down from sub-band 0 lands on sub-band 15 of the next lower oscillator.
- R8: ADC code 7 steps one sub-band up. Stepping up from sub-band 15 lands on sub-band 0 of the next higher oscillator.
- R9: A step requested below oscillator 0 sub-band 0, or above the top sub-band of the highest oscillator, ends the search with success = 0 and the last band held.
- R10: A step that would reverse direction for the second time in one search ends it with success = 0, keeping the band at which that step was requested.
- R11: A trigger during an active search restarts it from the chosen start point on the next cycle.
- R12: A search never selects oscillator code 3. A start point whose oscillator code is 3 is replaced by the highest oscillator with the same sub-band.
- R13: Clearing `auto_en` during a search aborts it. The next cycle shows the seed, idle = 1 and success = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | 1 = automatic search, 0 = manual selection from seed |
| trig | input | 1 | Single-cycle search start pulse |
| start_cur | input | 1 | 0 = start at seed, 1 = start at current selection |
| seed_osc | input | OSC_W (2) | Seed / manual oscillator code |
| seed_sub | input | SUB_W (4) | Seed / manual sub-band |
| wait_sel | input | 2 | Settle-time code, shift added to WAIT_BASE_LOG2 |
| adc_code | input | ADC_W (3) | Tuning-voltage window ADC code |
| settle_tick | input | 1 | Settle timing tick |
| osc_sel | output | OSC_W (2) | Selected oscillator |
| sub_sel | output | SUB_W (4) | Selected sub-band |
| srch_ok | output | 1 | 1 = last search succeeded |
| srch_idle | output | 1 | 1 = no search active |

## Verification
The bench builds the block with WAIT_BASE_LOG2 = 1, so the four wait codes give 2, 4, 8 and 16 ticks. With that setting a whole traversal across oscillator boundaries, both end-of-range failures and the double-reversal abort all fit in a few hundred cycles. The longest wait code is used with a tick on every other cycle, which shows that the judgement counts ticks rather than clocks. A simulated tuning-voltage plant turns the current band into ADC codes relative to a target, so each search converges or fails on its own.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_SEARCH
  } vbs_state_e;

  typedef enum logic [1:0] {
    DIR_NONE,
    DIR_UP,
    DIR_DOWN
  } vbs_dir_e;

  typedef enum logic [1:0] {
    VERDICT_LOCK,
    VERDICT_DOWN,
    VERDICT_UP
  } vbs_verdict_e;

endpackage

// File: rtl/vbs_adc_judge.sv
module vbs_adc_judge
  import vbs_pkg::*;
#(
  parameter int ADC_W = 3
) (
  input  logic [ADC_W-1:0] code,
  output vbs_verdict_e     verdict
);

  // All zeros: tuning voltage below window; all ones: above window.
  always_comb begin
    if (code == '0)      verdict = VERDICT_DOWN;
    else if (code == '1) verdict = VERDICT_UP;
    else                 verdict = VERDICT_LOCK;
  end

endmodule

// File: rtl/vbs_band_stepper.sv
module vbs_band_stepper #(
  parameter int NUM_OSC = 3,
  parameter int SUB_W   = 4,
  parameter int BAND_W  = 6
) (
  input  logic [BAND_W-1:0] band,
  input  logic              go_up,
  output logic [BAND_W-1:0] nxt_band,
  output logic              at_edge
);

  // Band index is {oscillator, sub-band}; a plain +/-1 carries across
  // oscillator boundaries because each oscillator owns 2**SUB_W bands.
  localparam int LAST_BAND = NUM_OSC * (1 << SUB_W) - 1;

  always_comb begin
    if (go_up) begin
      at_edge  = (band == BAND_W'(LAST_BAND));
      nxt_band = band + 1'b1;
    end else begin
      at_edge  = (band == '0);
      nxt_band = band - 1'b1;
    end
  end

endmodule

// File: rtl/vbs_settle_timer.sv
module vbs_settle_timer #(
  parameter int BASE_LOG2 = 6,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);

  localparam int MAX_SHIFT = BASE_LOG2 + (1 << SEL_W) - 1;
  localparam int CNT_W     = MAX_SHIFT + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;

  always_comb begin
    lim_m1 = (CNT_W'(1) << (BASE_LOG2 + int'(sel))) - 1'b1;
    expire = run && tick && (cnt_q == lim_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (expire) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
  import vbs_pkg::*;
#(
  parameter int NUM_OSC        = 3,
  parameter int OSC_W          = $clog2(NUM_OSC + 1),
  parameter int SUB_W          = 4,
  parameter int ADC_W          = 3,
  parameter int WAIT_SEL_W     = 2,
  parameter int WAIT_BASE_LOG2 = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  auto_en,
  input  logic                  trig,
  input  logic                  start_cur,
  input  logic [OSC_W-1:0]      seed_osc,
  input  logic [SUB_W-1:0]      seed_sub,
  input  logic [WAIT_SEL_W-1:0] wait_sel,
  input  logic [ADC_W-1:0]      adc_code,
  input  logic                  settle_tick,
  output logic [OSC_W-1:0]      osc_sel,
  output logic [SUB_W-1:0]      sub_sel,
  output logic                  srch_ok,
  output logic                  srch_idle
);

  localparam int BAND_W = OSC_W + SUB_W;

  vbs_state_e            st_q;
  vbs_dir_e              dir_q;
  logic                  rev_q;
  logic                  ok_q;
  logic [BAND_W-1:0]     band_q;
  logic [WAIT_SEL_W-1:0] wsel_q;

  logic [BAND_W-1:0] pick_band;
  logic [BAND_W-1:0] start_band;
  logic [BAND_W-1:0] nxt_band;
  logic              at_edge;
  logic              expire;
  logic              go_up;
  logic              reversal;
  logic              blocked;
  vbs_verdict_e      verdict;
  vbs_dir_e          want_dir;

  vbs_adc_judge #(.ADC_W(ADC_W)) u_judge (
    .code    (adc_code),
    .verdict (verdict)
  );

  assign go_up    = (verdict == VERDICT_UP);
  assign want_dir = go_up ? DIR_UP : DIR_DOWN;

  vbs_band_stepper #(.NUM_OSC(NUM_OSC), .SUB_W(SUB_W), .BAND_W(BAND_W)) u_step (
    .band     (band_q),
    .go_up    (go_up),
    .nxt_band (nxt_band),
    .at_edge  (at_edge)
  );

  vbs_settle_timer #(.BASE_LOG2(WAIT_BASE_LOG2), .SEL_W(WAIT_SEL_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (auto_en && trig),
    .run    (st_q == ST_SEARCH),
    .tick   (settle_tick),
    .sel    (wsel_q),
    .expire (expire)
  );

  // Start point: seed or current selection, shutdown code mapped to the top oscillator.
  always_comb begin
    pick_band = start_cur ? band_q : {seed_osc, seed_sub};
    if (pick_band[BAND_W-1 -: OSC_W] >= OSC_W'(NUM_OSC))
      start_band = {OSC_W'(NUM_OSC - 1), pick_band[SUB_W-1:0]};
    else
      start_band = pick_band;
  end

  always_comb begin
    reversal = (dir_q != DIR_NONE) && (dir_q != want_dir);
    blocked  = at_edge || (reversal && rev_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      band_q <= '0;
      ok_q   <= 1'b0;
      st_q   <= ST_IDLE;
      dir_q  <= DIR_NONE;
      rev_q  <= 1'b0;
      wsel_q <= '0;
    end else if (!auto_en) begin
      band_q <= {seed_osc, seed_sub};
      ok_q   <= 1'b0;
      st_q   <= ST_IDLE;
      dir_q  <= DIR_NONE;
      rev_q  <= 1'b0;
    end else if (trig) begin
      band_q <= start_band;
      ok_q   <= 1'b0;
      st_q   <= ST_SEARCH;
      dir_q  <= DIR_NONE;
      rev_q  <= 1'b0;
      wsel_q <= wait_sel;
    end else if (st_q == ST_SEARCH && expire) begin
      if (verdict == VERDICT_LOCK) begin
        st_q <= ST_IDLE;
        ok_q <= 1'b1;
      end else if (blocked) begin
        st_q <= ST_IDLE;
        ok_q <= 1'b0;
      end else begin
        band_q <= nxt_band;
        dir_q  <= want_dir;
        rev_q  <= rev_q | reversal;
      end
    end
  end

  assign osc_sel   = band_q[BAND_W-1 -: OSC_W];
  assign sub_sel   = band_q[SUB_W-1:0];
  assign srch_ok   = ok_q;
  assign srch_idle = (st_q == ST_IDLE);

endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
  parameter int OSC_W = 2,
  parameter int SUB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             auto_en,
  input logic             trig,
  input logic [OSC_W-1:0] seed_osc,
  input logic [SUB_W-1:0] seed_sub,
  input logic [OSC_W-1:0] osc_sel,
  input logic [SUB_W-1:0] sub_sel,
  input logic             srch_ok,
  input logic             srch_idle
);

  logic [OSC_W+SUB_W:0] idx;
  assign idx = {1'b0, osc_sel, sub_sel};

  assert_manual_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (!auto_en) |=> (osc_sel == $past(seed_osc) && sub_sel == $past(seed_sub)
                    && srch_idle && !srch_ok));

  assert_trigger_starts_R3: assert property (@(posedge clk) disable iff (rst)
    (auto_en && trig) |=> (!srch_idle && !srch_ok));

  assert_ok_only_idle_R6: assert property (@(posedge clk) disable iff (rst)
    srch_ok |-> srch_idle);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !trig && srch_idle) |=> ($stable(osc_sel) && $stable(sub_sel) && $stable(srch_ok)));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !trig && !srch_idle) |=>
      (idx == $past(idx) || idx == $past(idx) + 1'b1 || idx == $past(idx) - 1'b1));

  assert_no_shutdown_R12: assert property (@(posedge clk) disable iff (rst)
    (!srch_idle) |-> (osc_sel != '1));

endmodule

bind vco_band_search vbs_checker #(.OSC_W(OSC_W), .SUB_W(SUB_W)) u_vbs_checker (
  .clk       (clk),
  .rst       (rst),
  .auto_en   (auto_en),
  .trig      (trig),
  .seed_osc  (seed_osc),
  .seed_sub  (seed_sub),
  .osc_sel   (osc_sel),
  .sub_sel   (sub_sel),
  .srch_ok   (srch_ok),
  .srch_idle (srch_idle)
);

// File: tb/test_vco_band_search.sv
`timescale 1ns/1ps
module test_vco_band_search;

  localparam int BASE = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       auto_en = 1'b1;
  logic       trig = 1'b0;
  logic       start_cur = 1'b0;
  logic [1:0] seed_osc = '0;
  logic [3:0] seed_sub = '0;
  logic [1:0] wait_sel = '0;
  logic [2:0] adc_code = 3'd3;
  logic       settle_tick = 1'b1;
  logic [1:0] osc_sel;
  logic [3:0] sub_sel;
  logic       srch_ok;
  logic       srch_idle;

  always #5 clk = ~clk;

  vco_band_search #(.WAIT_BASE_LOG2(BASE)) i_vco_band_search (
    .clk(clk), .rst(rst), .auto_en(auto_en), .trig(trig), .start_cur(start_cur),
    .seed_osc(seed_osc), .seed_sub(seed_sub), .wait_sel(wait_sel), .adc_code(adc_code),
    .settle_tick(settle_tick), .osc_sel(osc_sel), .sub_sel(sub_sel),
    .srch_ok(srch_ok), .srch_idle(srch_idle)
  );

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    plant_on = 0;
  bit    tick_every = 1;
  int    target = 0;
  bit    finished = 0;

  // Behavioural reference model (band as integer index osc*16+sub)
  int m_band = 0, m_ok = 0, m_busy = 0, m_cnt = 0, m_lim = 2, m_dir = 0, m_rev = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_band = 0; m_ok = 0; m_busy = 0; m_cnt = 0; m_dir = 0; m_rev = 0;
    end else if (!auto_en) begin
      m_band = seed_osc * 16 + seed_sub; m_ok = 0; m_busy = 0; m_dir = 0; m_rev = 0;
    end else if (trig) begin
      int s;
      s = start_cur ? m_band : (seed_osc * 16 + seed_sub);
      if (s >= 48) s = 32 + (s % 16);
      m_band = s; m_ok = 0; m_busy = 1; m_cnt = 0; m_dir = 0; m_rev = 0;
      m_lim = (1 << BASE) << wait_sel;
    end else if (m_busy != 0 && settle_tick) begin
      if (m_cnt == m_lim - 1) begin
        m_cnt = 0;
        if (adc_code != 3'd0 && adc_code != 3'd7) begin
          m_busy = 0; m_ok = 1;
        end else begin
          int want, rv, edge_hit;
          want = (adc_code == 3'd7) ? 1 : -1;
          rv = (m_dir != 0 && m_dir != want) ? 1 : 0;
          edge_hit = ((want == 1 && m_band == 47) || (want == -1 && m_band == 0)) ? 1 : 0;
          if (edge_hit != 0 || (rv != 0 && m_rev != 0)) begin
            m_busy = 0; m_ok = 0;
          end else begin
            m_band = m_band + want; m_dir = want;
            if (rv != 0) m_rev = 1;
          end
        end
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string t, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", t, what, got, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(tag, "osc", osc_sel, m_band / 16);
    chk(tag, "sub", sub_sel, m_band % 16);
    chk(tag, "ok", srch_ok, m_ok);
    chk(tag, "idle", srch_idle, (m_busy != 0) ? 0 : 1);
    if (plant_on) adc_code = (m_band > target) ? 3'd0 : ((m_band < target) ? 3'd7 : 3'd3);
    settle_tick = tick_every ? 1'b1 : ~settle_tick;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic expect_st(input string t, input int o, input int s, input int ok, input int idle);
    chk(t, "osc(fixed)", osc_sel, o);
    chk(t, "sub(fixed)", sub_sel, s);
    chk(t, "ok(fixed)", srch_ok, ok);
    chk(t, "idle(fixed)", srch_idle, idle);
  endtask

  task automatic start(input int o, input int s, input bit cur, input int ws);
    seed_osc = 2'(o); seed_sub = 4'(s); start_cur = cur; wait_sel = 2'(ws);
    trig = 1'b1;
    cyc();
    trig = 1'b0;
  endtask

  initial begin
    // R1: reset state
    run(3);
    rst = 1'b0;
    cyc();
    expect_st("R1", 0, 0, 0, 1);

    // R2: manual selection follows seed, trigger ignored
    tag = "R2";
    auto_en = 1'b0; seed_osc = 2'd1; seed_sub = 4'd9; trig = 1'b1;
    cyc();
    expect_st("R2", 1, 9, 0, 1);
    trig = 1'b0; seed_osc = 2'd3; seed_sub = 4'd5;
    cyc();
    expect_st("R2", 3, 5, 0, 1);
    auto_en = 1'b1;
    run(3);
    expect_st("R6", 3, 5, 0, 1);

    // R3 / R6: start from seed, locked at first judgement
    tag = "R3"; plant_on = 1; target = 25; adc_code = 3'd3;
    start(1, 9, 0, 0);
    expect_st("R3", 1, 9, 0, 0);
    tag = "R6";
    run(4);
    expect_st("R6", 1, 9, 1, 1);

    // R7: step down across oscillator boundary
    tag = "R7"; target = 13;
    start(1, 1, 0, 0);
    run(20);
    expect_st("R7", 0, 13, 1, 1);

    // R8: step up across oscillator boundary, wait code 1
    tag = "R8"; target = 34;
    start(1, 14, 0, 1);
    run(30);
    expect_st("R8", 2, 2, 1, 1);

    // R4 / R5: start from current, longest wait with tick every other cycle
    tag = "R4"; target = 36; tick_every = 0;
    start(0, 0, 1, 3);
    run(5);
    expect_st("R4", 2, 2, 0, 0);
    tag = "R5";
    run(25);
    expect_st("R5", 2, 2, 0, 0);
    run(90);
    expect_st("R5", 2, 4, 1, 1);
    tick_every = 1;

    // R9: run off both ends
    tag = "R9"; target = -1;
    start(0, 2, 0, 0);
    run(12);
    expect_st("R9", 0, 0, 0, 1);
    target = 99;
    start(2, 13, 0, 0);
    run(12);
    expect_st("R9", 2, 15, 0, 1);

    // R10: second reversal aborts
    tag = "R10"; plant_on = 0; adc_code = 3'd7;
    start(1, 5, 0, 0);
    run(2);
    adc_code = 3'd0;
    run(2);
    adc_code = 3'd7;
    run(2);
    expect_st("R10", 1, 5, 0, 1);

    // R11: retrigger during search
    tag = "R11"; plant_on = 1; target = 0; adc_code = 3'd0;
    start(2, 10, 0, 0);
    run(5);
    start(0, 7, 0, 0);
    expect_st("R11", 0, 7, 0, 0);
    run(20);
    expect_st("R11", 0, 0, 1, 1);

    // R13: abort by clearing auto mode
    tag = "R13";
    start(2, 10, 0, 0);
    run(3);
    auto_en = 1'b0; seed_osc = 2'd1; seed_sub = 4'd3;
    cyc();
    expect_st("R13", 1, 3, 0, 1);
    auto_en = 1'b1;
    cyc();

    // R12: shutdown seed code replaced by top oscillator
    tag = "R12"; target = 38;
    start(3, 6, 0, 0);
    expect_st("R12", 2, 6, 0, 0);
    run(4);
    expect_st("R12", 2, 6, 1, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule